// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Reduced Instruction Set

The block is the serial test port of a device. It runs the usual sixteen-state controller that the test-mode-select line steers. Serial data moves in on the rising test-clock edge and out on the falling edge. A 3-bit instruction register chooses one of three data registers to place between serial-in and serial-out:

- a 1-bit bypass stage;
- a 32-bit identification word;
- a boundary register of parameterised length that samples a parallel vector of pin states.

The instruction set is reduced. The external-test code only samples the pins and asks the pad ring to float its outputs. The sample code never drives what was shifted in back onto the pins. There is no dedicated test reset. Holding test-mode-select high returns the port to its reset state. A power-on reset input sets the same state once at power-up.

A board-level tester walks the controller through instruction and data scans. The `hiz_req` output tells the surrounding pad logic when every functional output must be released. `tdo_oe` enables the serial output driver.

Top module: `scan_tap`

## Requirements
- R1: From any controller state, five consecutive rising `tck` edges with `tms` high put the controller in Test-Logic-Reset. The next data scan then returns the identification word.
- R2: In Test-Logic-Reset, and after `por_n` is released, the current instruction is IDCODE (001), and a data scan shifts out the identification word with bit 0 first.
- R3: Capture-IR loads the instruction shift stage with 001, so an instruction scan shifts out 1, 0, 0 in that order.
- R4: A shifted instruction takes effect only on the rising edge that leaves Update-IR. Before that edge, `hiz_req` keeps the value set by the previous instruction.
- R5: The identification word is as follows. Bit 0 is 1. Bits 11:1 hold the vendor code 00011100100. Bits 17:12 are 0. Bits 22:18 hold the width code 00011. Bits 27:23 hold the depth code 00111. Bits 31:28 hold the revision, which is 0 by default.
- R6: `tdi` enters the most significant bit of the selected register and `tdo` shows its least significant bit, so data shifts through each register with a delay equal to its length. The lengths are 1 for bypass, 32 for identification and BSR_W for the boundary register.
- R7: BYPASS (111) and the unused codes 011, 101 and 110 select the 1-bit bypass stage. That stage captures 0.
- R8: EXTEST (000) and SAMPLE-Z (010) capture `pins_i` into the boundary register, select it for shifting, and drive `hiz_req` high.
- R9: SAMPLE (100) captures `pins_i` into the boundary register with `hiz_req` low. Its Update-DR has no effect, so the next capture again shows the live pins and not the shifted data.
- R10: `tdo_oe` is high only in the half cycles that follow a falling edge taken in Shift-IR or Shift-DR.
- R11: While `por_n` is low, the controller is in Test-Logic-Reset, `tdo_oe` is low and `hiz_req` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| tms | input | 1 | Test mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| pins_i | input | BSR_W | Parallel pin states sampled by the boundary register |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_oe | output | 1 | Driver enable for `tdo` |
| hiz_req | output | 1 | Request to float all functional outputs |

## Verification
The assertions assume that `tms` and `tdi` change only away from the rising `tck` edge. They also assume that `pins_i` is steady across the edge that leaves Capture-DR. The bench changes all inputs a little after each falling edge and changes `pins_i` only while the controller idles. Stimulus mixes random instruction codes, random pin vectors, random `tms` walks and random serial data. These are paired with directed scans of the pause states, of the delayed instruction update and of reset from an arbitrary state.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

  localparam int IR_W = 3;

  typedef enum logic [3:0] {
    S_TLR, S_RTI,
    S_SEL_DR, S_CAP_DR, S_SHF_DR, S_EX1_DR, S_PAU_DR, S_EX2_DR, S_UPD_DR,
    S_SEL_IR, S_CAP_IR, S_SHF_IR, S_EX1_IR, S_PAU_IR, S_EX2_IR, S_UPD_IR
  } tap_state_t;

  typedef enum logic [1:0] {DR_BYP, DR_ID, DR_BSR} dr_sel_t;

  localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
  localparam logic [IR_W-1:0] OP_IDCODE  = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPLEZ = 3'b010;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b100;
  localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;

  function automatic tap_state_t tap_next(input tap_state_t s, input logic m);
    case (s)
      S_TLR:    return m ? S_TLR    : S_RTI;
      S_RTI:    return m ? S_SEL_DR : S_RTI;
      S_SEL_DR: return m ? S_SEL_IR : S_CAP_DR;
      S_CAP_DR: return m ? S_EX1_DR : S_SHF_DR;
      S_SHF_DR: return m ? S_EX1_DR : S_SHF_DR;
      S_EX1_DR: return m ? S_UPD_DR : S_PAU_DR;
      S_PAU_DR: return m ? S_EX2_DR : S_PAU_DR;
      S_EX2_DR: return m ? S_UPD_DR : S_SHF_DR;
      S_UPD_DR: return m ? S_SEL_DR : S_RTI;
      S_SEL_IR: return m ? S_TLR    : S_CAP_IR;
      S_CAP_IR: return m ? S_EX1_IR : S_SHF_IR;
      S_SHF_IR: return m ? S_EX1_IR : S_SHF_IR;
      S_EX1_IR: return m ? S_UPD_IR : S_PAU_IR;
      S_PAU_IR: return m ? S_EX2_IR : S_PAU_IR;
      S_EX2_IR: return m ? S_UPD_IR : S_SHF_IR;
      S_UPD_IR: return m ? S_SEL_DR : S_RTI;
      default:  return S_TLR;
    endcase
  endfunction

  function automatic dr_sel_t op_select(input logic [IR_W-1:0] op);
    case (op)
      OP_EXTEST, OP_SAMPLEZ, OP_SAMPLE: return DR_BSR;
      OP_IDCODE:                        return DR_ID;
      default:                          return DR_BYP;
    endcase
  endfunction

  function automatic logic op_floats(input logic [IR_W-1:0] op);
    return (op == OP_EXTEST) || (op == OP_SAMPLEZ);
  endfunction

  function automatic logic [31:0] id_word(input logic [3:0] rev, input logic [4:0] depth,
                                          input logic [4:0] width, input logic [10:0] vendor);
    return {rev, depth, width, 6'b000000, vendor, 1'b1};
  endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import scan_tap_pkg::*;
(
  input  logic       tck,
  input  logic       por_n,
  input  logic       tms,
  output tap_state_t state
);

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) state <= S_TLR;
    else        state <= tap_next(state, tms);
  end

  // run of consecutive high tms samples, saturating at five
  logic [2:0] ones_run;
  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)                 ones_run <= 3'd0;
    else if (!tms)              ones_run <= 3'd0;
    else if (ones_run != 3'd5)  ones_run <= ones_run + 3'd1;
  end

  a_r1_five_ones_reset: assert property (@(posedge tck) disable iff (!por_n)
    (ones_run == 3'd5) |-> (state == S_TLR));

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import scan_tap_pkg::*;
(
  input  logic            tck,
  input  logic            por_n,
  input  tap_state_t      state,
  input  logic            tdi,
  output logic [IR_W-1:0] ir_q,
  output logic            ir_lsb
);

  logic [IR_W-1:0] ir_sh;

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) ir_sh <= '0;
    else if (state == S_CAP_IR) ir_sh <= {{(IR_W-2){1'b0}}, 2'b01};
    else if (state == S_SHF_IR) ir_sh <= {tdi, ir_sh[IR_W-1:1]};
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)                 ir_q <= OP_IDCODE;
    else if (state == S_TLR)    ir_q <= OP_IDCODE;
    else if (state == S_UPD_IR) ir_q <= ir_sh;
  end

  assign ir_lsb = ir_sh[0];

  a_r2_reset_idcode: assert property (@(posedge tck) disable iff (!por_n)
    (state == S_TLR) |=> (ir_q == OP_IDCODE));

  a_r3_capture_pattern: assert property (@(posedge tck) disable iff (!por_n)
    (state == S_CAP_IR) |=> (ir_sh[1:0] == 2'b01));

  a_r4_update_only: assert property (@(posedge tck) disable iff (!por_n)
    !(state == S_TLR || state == S_UPD_IR) |=> $stable(ir_q));

endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import scan_tap_pkg::*;
#(
  parameter int         BSR_W  = 8,
  parameter logic [31:0] ID_VAL = 32'h0
) (
  input  logic             tck,
  input  logic             por_n,
  input  tap_state_t       state,
  input  dr_sel_t          sel,
  input  logic             tdi,
  input  logic [BSR_W-1:0] pins_i,
  output logic             dr_lsb
);

  logic             byp_q;
  logic [31:0]      id_q;
  logic [BSR_W-1:0] bsr_q;

  wire cap = (state == S_CAP_DR);
  wire shf = (state == S_SHF_DR);

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      byp_q <= 1'b0;
      id_q  <= '0;
      bsr_q <= '0;
    end else begin
      case (sel)
        DR_BYP: if (cap) byp_q <= 1'b0;
                else if (shf) byp_q <= tdi;
        DR_ID:  if (cap) id_q <= ID_VAL;
                else if (shf) id_q <= {tdi, id_q[31:1]};
        DR_BSR: if (cap) bsr_q <= pins_i;
                else if (shf) bsr_q <= {tdi, bsr_q[BSR_W-1:1]};
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      DR_ID:   dr_lsb = id_q[0];
      DR_BSR:  dr_lsb = bsr_q[0];
      default: dr_lsb = byp_q;
    endcase
  end

  a_r7_bypass_zero: assert property (@(posedge tck) disable iff (!por_n)
    (cap && sel == DR_BYP) |=> (byp_q == 1'b0));

  a_r8_bsr_capture: assert property (@(posedge tck) disable iff (!por_n)
    (cap && sel == DR_BSR) |=> (bsr_q == $past(pins_i)));

  a_r9_bsr_hold: assert property (@(posedge tck) disable iff (!por_n)
    !(cap || shf) |=> $stable(bsr_q));

endmodule

// File: rtl/scan_tap.sv
module scan_tap
  import scan_tap_pkg::*;
#(
  parameter int          BSR_W       = 8,
  parameter logic [3:0]  REV_CODE    = 4'h0,
  parameter logic [4:0]  DEPTH_CODE  = 5'b00111,
  parameter logic [4:0]  WIDTH_CODE  = 5'b00011,
  parameter logic [10:0] VENDOR_CODE = 11'b00011100100
) (
  input  logic             tck,
  input  logic             por_n,
  input  logic             tms,
  input  logic             tdi,
  input  logic [BSR_W-1:0] pins_i,
  output logic             tdo,
  output logic             tdo_oe,
  output logic             hiz_req
);

  localparam logic [31:0] ID_VAL = id_word(REV_CODE, DEPTH_CODE, WIDTH_CODE, VENDOR_CODE);

  tap_state_t      state;
  logic [IR_W-1:0] ir_q;
  logic            ir_lsb, dr_lsb;
  dr_sel_t         sel;

  tap_fsm u_fsm (.tck(tck), .por_n(por_n), .tms(tms), .state(state));

  tap_ir u_ir (.tck(tck), .por_n(por_n), .state(state), .tdi(tdi),
               .ir_q(ir_q), .ir_lsb(ir_lsb));

  assign sel     = op_select(ir_q);
  assign hiz_req = op_floats(ir_q);

  tap_dr #(.BSR_W(BSR_W), .ID_VAL(ID_VAL)) u_dr (
    .tck(tck), .por_n(por_n), .state(state), .sel(sel), .tdi(tdi),
    .pins_i(pins_i), .dr_lsb(dr_lsb));

  wire in_shift = (state == S_SHF_IR) || (state == S_SHF_DR);
  wire ser_bit  = (state == S_SHF_IR) ? ir_lsb : dr_lsb;

  always_ff @(negedge tck or negedge por_n) begin
    if (!por_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= ser_bit;
      tdo_oe <= in_shift;
    end
  end

  a_r10_oe_only_shift: assert property (@(posedge tck) disable iff (!por_n)
    tdo_oe |-> (state == S_SHF_IR || state == S_SHF_DR));

endmodule

// File: tb/scan_tap_bench.sv
`timescale 1ns/1ps
module scan_tap_bench;
  localparam int BSR_W = 8;

  logic tck = 1'b0;
  logic por_n = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic [BSR_W-1:0] pins = '0;
  logic tdo, tdo_oe, hiz_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 tck = ~tck;

  scan_tap #(.BSR_W(BSR_W)) u_scan_tap (
    .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .pins_i(pins),
    .tdo(tdo), .tdo_oe(tdo_oe), .hiz_req(hiz_req));

  function automatic logic [31:0] exp_id();
    logic [31:0] w;
    w = '0;
    w[0] = 1'b1;
    w[11:1] = 11'b00011100100;
    w[22:18] = 5'b00011;
    w[27:23] = 5'b00111;
    return w;
  endfunction

  function automatic int exp_len(input logic [2:0] op);
    if (op == 3'b000 || op == 3'b010 || op == 3'b100) return BSR_W;
    if (op == 3'b001) return 32;
    return 1;
  endfunction

  function automatic logic [63:0] exp_cap(input logic [2:0] op, input logic [BSR_W-1:0] p);
    if (exp_len(op) == BSR_W && op != 3'b001 && op != 3'b111) return 64'(p);
    if (op == 3'b001) return 64'(exp_id());
    return 64'h0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck); @(negedge tck); #2;
  endtask

  task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
    dout = '0;
    step(1, 0); step(0, 0); step(0, 0);
    chk(tdo_oe === 1'b1, "R10 oe in Shift-DR", 64'(tdo_oe), 64'd1);
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      step(i == n-1, din[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic scan_ir(input logic [2:0] op, output logic [2:0] cap, output logic hz_before);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 3; i++) begin
      cap[i] = tdo;
      step(i == 2, op[i]);
    end
    step(1, 0);
    hz_before = hiz_req;
    step(0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge tck);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] dout, din, expv;
    logic [2:0] cap;
    logic hzb;
    void'($urandom(32'd1234));
    repeat (3) @(negedge tck);
    #2;
    chk(tdo_oe === 1'b0 && hiz_req === 1'b0, "R11 reset outputs", {tdo_oe, hiz_req}, 64'd0);
    por_n = 1'b1;
    step(1, 0);
    step(0, 0);
    chk(tdo_oe === 1'b0, "R10 oe low in idle", 64'(tdo_oe), 64'd0);

    // R2 / R5: identification word after power-up
    scan_dr(32, 64'h0, dout);
    chk(dout[31:0] === exp_id(), "R2 id after power-up", dout, 64'(exp_id()));
    chk(dout[0] === 1'b1 && dout[11:1] === 11'b00011100100, "R5 vendor/presence", dout, 64'(exp_id()));
    chk(dout[27:23] === 5'b00111 && dout[22:18] === 5'b00011 && dout[17:12] === 6'd0,
        "R5 depth/width/reserved", dout, 64'(exp_id()));

    // R3: capture pattern
    scan_ir(3'b100, cap, hzb);
    chk(cap === 3'b001, "R3 capture-IR pattern", 64'(cap), 64'd1);

    // R4: EXTEST takes effect only after Update-IR
    scan_ir(3'b000, cap, hzb);
    chk(hzb === 1'b0, "R4 hiz before update", 64'(hzb), 64'd0);
    chk(hiz_req === 1'b1, "R4 hiz after update", 64'(hiz_req), 64'd1);

    // R9: SAMPLE update has no effect
    scan_ir(3'b100, cap, hzb);
    chk(hiz_req === 1'b0, "R9 sample no hiz", 64'(hiz_req), 64'd0);
    pins = 8'hA5;
    scan_dr(BSR_W, 64'h3C, dout);
    chk(dout[BSR_W-1:0] === 8'hA5, "R9 first capture", dout, 64'hA5);
    pins = 8'h5A;
    scan_dr(BSR_W, 64'h00, dout);
    chk(dout[BSR_W-1:0] === 8'h5A, "R9 live pins after update", dout, 64'h5A);

    // R10: Pause-DR releases the driver
    step(1, 0); step(0, 0); step(0, 0);
    step(1, 0); step(0, 0);
    chk(tdo_oe === 1'b0, "R10 oe low in Pause-DR", 64'(tdo_oe), 64'd0);
    step(1, 0); step(1, 0); step(0, 0);

    // R6/R7/R8/R9 random instructions
    for (int k = 0; k < 32; k++) begin
      logic [2:0] op;
      int n;
      op = 3'($urandom);
      pins = BSR_W'($urandom);
      scan_ir(op, cap, hzb);
      chk(hiz_req === (op == 3'b000 || op == 3'b010), "R8/R9 hiz for code", 64'(hiz_req),
          64'(op == 3'b000 || op == 3'b010));
      n = exp_len(op) + 8;
      din = {$urandom, $urandom};
      scan_dr(n, din, dout);
      expv = exp_cap(op, pins) | (din << exp_len(op));
      if (n < 64) begin
        expv = expv & ((64'd1 << n) - 64'd1);
        dout = dout & ((64'd1 << n) - 64'd1);
      end
      if (exp_len(op) == 1) chk(dout === expv, "R7 bypass path", dout, expv);
      else chk(dout === expv, "R6/R8 register path", dout, expv);
    end

    // R1: reset from an arbitrary state by five high tms samples
    scan_ir(3'b111, cap, hzb);
    for (int w = 0; w < 17; w++) step(1'($urandom), 1'($urandom));
    for (int w = 0; w < 5; w++) step(1, 0);
    step(0, 0);
    chk(hiz_req === 1'b0, "R1 hiz after tms reset", 64'(hiz_req), 64'd0);
    scan_dr(32, 64'h0, dout);
    chk(dout[31:0] === exp_id(), "R1 id after tms reset", dout, 64'(exp_id()));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule